// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each received frame, whether its destination address is admitted by a 64-bin hash table. The 48-bit destination is folded into a 6-bit bin number. The table bit for that bin is looked up and gated by one of two enables. The multicast enable applies when the address is a group address. The unicast enable applies otherwise. The verdict appears one cycle after the lookup strobe.

The table can be written directly, one 32-bit half at a time. It can also be maintained by a reference-count engine. Add and remove commands carry a MAC address. The engine keeps an 8-bit count per bin and changes the table bit only when a count leaves or reaches zero.

An all-multicast command forces every table bit to one. A later return command rebuilds the table from the bins whose counts are nonzero.

The command engine is a three-state machine:
- `ST_IDLE` waits for a command or a table write.
- `ST_APPLY` updates the count and the table bit of the hashed bin.
- `ST_REBUILD` copies the nonzero-count map into the table.

Transitions:
- `ST_IDLE`→`ST_APPLY` on an add or remove command.
- `ST_IDLE`→`ST_REBUILD` on the return-to-filtering command.
- `ST_IDLE`→`ST_IDLE` on the all-multicast command or a table write.
- `ST_APPLY`→`ST_IDLE` and `ST_REBUILD`→`ST_IDLE` always, after one cycle.

Top module: `mcast_hash_filter`

## Requirements
- R1: The bin number of an address `a[47:0]` is the XOR of the eight 6-bit fields `a[6k+5:6k]`, k = 0..7. Byte 0 of the address occupies `a[7:0]`.
- R2: Bin i lives in bit i of `table_lo` for i < 32, and in bit i-32 of `table_hi` otherwise. A table write with `tbl_wr_top`=0 replaces `table_lo`; with `tbl_wr_top`=1 it replaces `table_hi`. The new value is visible after the clock edge that samples the write.
- R3: A lookup sampled with `lu_valid` gives `res_valid`=1 after that edge. `res_accept` is 1 only if the table bit of the address's bin is 1 and the relevant enable is set. The relevant enable is `mc_hash_en` when `lu_dest[0]`=1 (group address), and `uc_hash_en` otherwise. Without `lu_valid`, `res_valid` is 0 after the edge.
- R4: Command encodings on `cmd_op` are 0 add, 1 remove, 2 all-multicast on, 3 all-multicast off. An add sets the bin's table bit when its count was 0 and increments the count. `cmd_busy` is high for exactly the one cycle after the command edge. The table shows the result after the second edge.
- R5: A remove on a count of 1 clears the table bit and leaves the count at 0. A remove on a larger count decrements it and leaves the bit alone.
- R6: A remove on a bin whose count is 0 changes neither the count nor the table.
- R7: Counts saturate at 255. Further adds leave the count at 255, so 255 removes then bring it to 0.
- R8: All-multicast on sets both halves to all ones after the command edge. While the mode is on, add and remove change counts only, and the table stays all ones.
- R9: All-multicast off leaves the mode. After the second edge, the table holds a one for exactly the bins with nonzero counts.
- R10: After reset, both table halves and all counts are 0, and `cmd_busy` and `res_valid` are 0.
- R11: Commands and table writes presented while `cmd_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lu_valid | input | 1 | Lookup strobe |
| lu_dest | input | 48 | Destination address to classify |
| mc_hash_en | input | 1 | Enable hash matching of group addresses |
| uc_hash_en | input | 1 | Enable hash matching of individual addresses |
| res_valid | output | 1 | Lookup result valid |
| res_accept | output | 1 | Frame admitted by the hash table |
| tbl_wr_en | input | 1 | Direct table half write |
| tbl_wr_top | input | 1 | Selects the upper half (bins 32..63) |
| tbl_wr_data | input | 32 | Half contents |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | 48 | Address for add and remove |
| cmd_busy | output | 1 | Engine busy; inputs ignored |
| table_lo | output | 32 | Table bins 0..31 |
| table_hi | output | 32 | Table bins 32..63 |

## Verification
The latencies checked are:
- A lookup verdict is due one edge after its strobe.
- A table write and the all-multicast command take effect one edge after they are sampled.
- Add, remove and return-to-filtering take effect two edges after they are sampled, with `cmd_busy` high in between.

The bench drives every input at a falling edge and reads results at the following falling edges. It holds every command for one cycle and then waits one more cycle before it reads the table. A reference model in the bench computes the bin numbers byte by byte and tracks the counts, so the latencies and the count rules are both checked.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_REMOVE  = 2'd1,
        OP_ALL_ON  = 2'd2,
        OP_ALL_OFF = 2'd3
    } mhf_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_APPLY   = 2'd1,
        ST_REBUILD = 2'd2
    } mhf_state_e;
endpackage

// File: rtl/mhf_hash_fold.sv
module mhf_hash_fold #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [HASH_W-1:0] hash
);
    localparam int SLICES = ADDR_W / HASH_W;

    // R1: XOR of consecutive HASH_W-bit fields
    always_comb begin
        hash = '0;
        for (int k = 0; k < SLICES; k++) begin
            hash = hash ^ addr[k*HASH_W +: HASH_W];
        end
    end
endmodule

// File: rtl/mhf_ref_bins.sv
module mhf_ref_bins #(
    parameter int HASH_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd_en,
    input  logic                  upd_inc,
    input  logic [HASH_W-1:0]     upd_bin,
    output logic [CNT_W-1:0]      sel_cnt,
    output logic [(1<<HASH_W)-1:0] nonzero
);
    localparam int NBINS = 1 << HASH_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NBINS];

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (upd_en && (upd_bin == HASH_W'(g))) begin
                if (upd_inc) begin
                    if (cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + 1'b1;
                end else begin
                    if (cnt_q[g] != '0) cnt_q[g] <= cnt_q[g] - 1'b1;
                end
            end
        end
        assign nonzero[g] = |cnt_q[g];
    end

    assign sel_cnt = cnt_q[upd_bin];

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_inc && sel_cnt == CNT_MAX) |=> (cnt_q[$past(upd_bin)] == CNT_MAX));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_inc && sel_cnt == '0) |=> (cnt_q[$past(upd_bin)] == '0));
endmodule

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
    import mhf_pkg::*;
#(
    parameter int HASH_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [HASH_W-1:0]      cmd_hash,
    input  logic                   tbl_wr_en,
    input  logic                   tbl_wr_top,
    input  logic [(1<<HASH_W)/2-1:0] tbl_wr_data,
    input  logic [CNT_W-1:0]       sel_cnt,
    input  logic [(1<<HASH_W)-1:0] nonzero,
    output logic                   upd_en,
    output logic                   upd_inc,
    output logic [HASH_W-1:0]      upd_bin,
    output logic [(1<<HASH_W)-1:0] table_q,
    output logic                   busy
);
    localparam int NBINS = 1 << HASH_W;
    localparam int HALF  = NBINS / 2;

    mhf_state_e state_q, state_d;
    mhf_op_e    op_q;
    logic [HASH_W-1:0] bin_q;
    logic       all_q;
    mhf_op_e    op_in;
    logic       take_cmd;

    assign op_in    = mhf_op_e'(cmd_op);
    assign take_cmd = (state_q == ST_IDLE) && cmd_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (op_in == OP_ADD || op_in == OP_REMOVE) state_d = ST_APPLY;
                    else if (op_in == OP_ALL_OFF)              state_d = ST_REBUILD;
                end
            end
            ST_APPLY:   state_d = ST_IDLE;
            ST_REBUILD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs toward the count bank
    always_comb begin
        upd_en  = (state_q == ST_APPLY);
        upd_inc = (op_q == OP_ADD);
        upd_bin = bin_q;
        busy    = (state_q != ST_IDLE);
    end

    // table, mode and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_q <= '0;
            all_q   <= 1'b0;
            op_q    <= OP_ADD;
            bin_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q  <= op_in;
                        bin_q <= cmd_hash;
                        if (op_in == OP_ALL_ON) begin
                            table_q <= '1;
                            all_q   <= 1'b1;
                        end else if (op_in == OP_ALL_OFF) begin
                            all_q <= 1'b0;
                        end
                    end else if (tbl_wr_en) begin
                        if (tbl_wr_top) table_q[NBINS-1:HALF] <= tbl_wr_data;
                        else            table_q[HALF-1:0]     <= tbl_wr_data;
                    end
                end
                ST_APPLY: begin
                    if (!all_q) begin
                        if (op_q == OP_ADD && sel_cnt == '0)
                            table_q[bin_q] <= 1'b1;
                        else if (op_q == OP_REMOVE && sel_cnt == CNT_W'(1))
                            table_q[bin_q] <= 1'b0;
                    end
                end
                ST_REBUILD: table_q <= nonzero;
                default: ;
            endcase
        end
    end

    assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> !busy);

    assert_all_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && op_in == OP_ALL_ON) |=> (&table_q));

    assert_rebuild_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REBUILD) |=> (table_q == $past(nonzero)));

    assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_APPLY && !all_q) |=> ($countones(table_q ^ $past(table_q)) <= 1));
endmodule

// File: rtl/mhf_match.sv
module mhf_match #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lu_valid,
    input  logic [ADDR_W-1:0]      lu_dest,
    input  logic [HASH_W-1:0]      lu_hash,
    input  logic                   mc_en,
    input  logic                   uc_en,
    input  logic [(1<<HASH_W)-1:0] table_q,
    output logic                   res_valid,
    output logic                   res_accept
);
    logic group_addr;
    logic hit;

    assign group_addr = lu_dest[0];
    assign hit        = table_q[lu_hash] & (group_addr ? mc_en : uc_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_valid  <= lu_valid;
            res_accept <= lu_valid & hit;
        end
    end

    assert_uc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_valid && !lu_dest[0] && !uc_en) |=> !res_accept);

    assert_mc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_valid && lu_dest[0] && !mc_en) |=> !res_accept);

    assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lu_valid |=> (!res_valid && !res_accept));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 6,
    parameter int CNT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lu_valid,
    input  logic [ADDR_W-1:0]          lu_dest,
    input  logic                       mc_hash_en,
    input  logic                       uc_hash_en,
    output logic                       res_valid,
    output logic                       res_accept,
    input  logic                       tbl_wr_en,
    input  logic                       tbl_wr_top,
    input  logic [(1<<HASH_W)/2-1:0]   tbl_wr_data,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [ADDR_W-1:0]          cmd_addr,
    output logic                       cmd_busy,
    output logic [(1<<HASH_W)/2-1:0]   table_lo,
    output logic [(1<<HASH_W)/2-1:0]   table_hi
);
    localparam int NBINS = 1 << HASH_W;
    localparam int HALF  = NBINS / 2;

    logic [HASH_W-1:0] lu_hash, cmd_hash, upd_bin;
    logic [CNT_W-1:0]  sel_cnt;
    logic [NBINS-1:0]  nonzero, table_q;
    logic              upd_en, upd_inc;

    mhf_hash_fold #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_fold_lu (
        .addr(lu_dest), .hash(lu_hash));

    mhf_hash_fold #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_fold_cmd (
        .addr(cmd_addr), .hash(cmd_hash));

    mhf_ref_bins #(.HASH_W(HASH_W), .CNT_W(CNT_W)) u_bins (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_inc(upd_inc),
        .upd_bin(upd_bin), .sel_cnt(sel_cnt), .nonzero(nonzero));

    mhf_ctrl #(.HASH_W(HASH_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_hash(cmd_hash), .tbl_wr_en(tbl_wr_en), .tbl_wr_top(tbl_wr_top),
        .tbl_wr_data(tbl_wr_data), .sel_cnt(sel_cnt), .nonzero(nonzero),
        .upd_en(upd_en), .upd_inc(upd_inc), .upd_bin(upd_bin),
        .table_q(table_q), .busy(cmd_busy));

    mhf_match #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_match (
        .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_dest(lu_dest),
        .lu_hash(lu_hash), .mc_en(mc_hash_en), .uc_en(uc_hash_en),
        .table_q(table_q), .res_valid(res_valid), .res_accept(res_accept));

    assign table_lo = table_q[HALF-1:0];
    assign table_hi = table_q[NBINS-1:HALF];
endmodule

// File: tb/tb_mcast_hash_filter.sv
module tb_mcast_hash_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lu_valid = 1'b0;
    logic [47:0] lu_dest = '0;
    logic        mc_hash_en = 1'b0, uc_hash_en = 1'b0;
    logic        res_valid, res_accept;
    logic        tbl_wr_en = 1'b0, tbl_wr_top = 1'b0;
    logic [31:0] tbl_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [47:0] cmd_addr = '0;
    logic        cmd_busy;
    logic [31:0] table_lo, table_hi;

    int checks = 0;
    int failures = 0;

    logic [63:0] m_tab = '0;
    int          m_cnt [64];
    bit          m_all = 0;

    always #10ns clk = ~clk;

    mcast_hash_filter dut (
        .clk(clk), .rst_n(rst_n), .lu_valid(lu_valid), .lu_dest(lu_dest),
        .mc_hash_en(mc_hash_en), .uc_hash_en(uc_hash_en),
        .res_valid(res_valid), .res_accept(res_accept),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_top(tbl_wr_top), .tbl_wr_data(tbl_wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_busy(cmd_busy), .table_lo(table_lo), .table_hi(table_hi));

    // byte-oriented reference for R1
    function automatic logic [5:0] ref_hash(input logic [47:0] a);
        logic [7:0] b [6];
        logic [5:0] h;
        for (int i = 0; i < 6; i++) b[i] = a[8*i +: 8];
        h = '0;
        for (int g = 0; g < 2; g++) begin
            h ^= b[3*g][5:0];
            h ^= {b[3*g+1][3:0], b[3*g][7:6]};
            h ^= {b[3*g+2][1:0], b[3*g+1][7:4]};
            h ^= b[3*g+2][7:2];
        end
        return h;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_cmd(input logic [1:0] op, input logic [47:0] a);
        int h;
        h = int'(ref_hash(a));
        case (op)
            2'd0: begin
                if (m_cnt[h] == 0 && !m_all) m_tab[h] = 1'b1;
                if (m_cnt[h] < 255) m_cnt[h]++;
            end
            2'd1: if (m_cnt[h] != 0) begin
                if (m_cnt[h] == 1 && !m_all) m_tab[h] = 1'b0;
                m_cnt[h]--;
            end
            2'd2: begin m_tab = '1; m_all = 1; end
            default: begin
                m_all = 0;
                for (int i = 0; i < 64; i++) m_tab[i] = (m_cnt[i] != 0);
            end
        endcase
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [47:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        model_cmd(op, a);
    endtask

    task automatic sw_write(input logic top, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_top = top; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        if (top) m_tab[63:32] = d; else m_tab[31:0] = d;
    endtask

    task automatic lookup(input string req, input logic [47:0] a, input logic mc, input logic uc);
        logic en;
        @(negedge clk);
        lu_valid = 1'b1; lu_dest = a; mc_hash_en = mc; uc_hash_en = uc;
        @(negedge clk);
        lu_valid = 1'b0;
        en = a[0] ? mc : uc;
        chk(req, {62'd0, res_valid, res_accept}, {62'd0, 1'b1, en & m_tab[ref_hash(a)]});
    endtask

    // {mc_en, uc_en, address}
    localparam logic [49:0] VEC [10] = '{
        {2'b10, 48'h5E00_0000_0001},
        {2'b10, 48'h0000_0000_0033},
        {2'b01, 48'h1234_5678_9ABC},
        {2'b11, 48'hFFFF_FFFF_FFFF},
        {2'b01, 48'hA5A5_A5A5_A5A4},
        {2'b00, 48'h0102_0304_0507},
        {2'b11, 48'h0000_0000_0000},
        {2'b10, 48'hDEAD_BEEF_0123},
        {2'b11, 48'h7F00_0000_5E01},
        {2'b01, 48'h0000_0000_5E01}
    };

    initial begin
        #(20ns * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [47:0] ADDR_A = 48'h0300_005E_0001;
    localparam logic [47:0] ADDR_B = 48'h1100_2233_4401;
    localparam logic [47:0] ADDR_C = 48'hC0FF_EE00_1207;

    initial begin
        for (int i = 0; i < 64; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 table", {table_hi, table_lo}, 64'd0);
        chk("R10 busy/valid", {62'd0, cmd_busy, res_valid}, 64'd0);
        rst_n = 1'b1;

        // R2 direct writes land in the right half
        sw_write(1'b0, 32'hA5C3_0F69);
        chk("R2 low half", {table_hi, table_lo}, m_tab);
        sw_write(1'b1, 32'h1E2D_3C4B);
        chk("R2 high half", {table_hi, table_lo}, m_tab);

        // R3 lookup vectors against the written table
        for (int v = 0; v < 10; v++) begin
            lookup("R3 vector", VEC[v][47:0], VEC[v][49], VEC[v][48]);
        end
        @(negedge clk);
        chk("R3 no strobe", {63'd0, res_valid}, 64'd0);

        sw_write(1'b0, 32'd0);
        sw_write(1'b1, 32'd0);

        // R1/R4 add sets exactly the reference bin; busy for one cycle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = ADDR_A;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R4 busy high", {63'd0, cmd_busy}, 64'd1);
        @(negedge clk);
        chk("R4 busy low", {63'd0, cmd_busy}, 64'd0);
        model_cmd(2'd0, ADDR_A);
        chk("R1 hash bin of add", {table_hi, table_lo}, 64'd1 << ref_hash(ADDR_A));

        // R5 count above one keeps the bit, last remove clears
        run_cmd(2'd0, ADDR_A);
        run_cmd(2'd1, ADDR_A);
        chk("R5 decrement keeps bit", {table_hi, table_lo}, m_tab);
        run_cmd(2'd1, ADDR_A);
        chk("R5 last remove clears", {table_hi, table_lo}, 64'd0);

        // R6 remove on zero ignored; one add then one remove clears again
        run_cmd(2'd1, ADDR_A);
        chk("R6 remove on zero", {table_hi, table_lo}, 64'd0);
        run_cmd(2'd0, ADDR_A);
        run_cmd(2'd1, ADDR_A);
        chk("R6 count stayed zero", {table_hi, table_lo}, 64'd0);

        // R7 saturation: 300 adds, 254 removes keep bit, 255th clears
        for (int i = 0; i < 300; i++) run_cmd(2'd0, ADDR_B);
        for (int i = 0; i < 254; i++) run_cmd(2'd1, ADDR_B);
        chk("R7 still set", {table_hi, table_lo}, 64'd1 << ref_hash(ADDR_B));
        run_cmd(2'd1, ADDR_B);
        chk("R7 cleared at 255th", {table_hi, table_lo}, 64'd0);

        // R8 all-multicast, counts tracked while table stays ones
        run_cmd(2'd0, ADDR_A);
        run_cmd(2'd2, '0);
        chk("R8 all ones", {table_hi, table_lo}, {64{1'b1}});
        run_cmd(2'd0, ADDR_C);
        run_cmd(2'd1, ADDR_A);
        chk("R8 table held", {table_hi, table_lo}, {64{1'b1}});
        lookup("R8 accept any group", ADDR_B, 1'b1, 1'b0);

        // R9 rebuild from counts
        run_cmd(2'd3, '0);
        chk("R9 rebuild", {table_hi, table_lo}, 64'd1 << ref_hash(ADDR_C));

        // R11 write during busy ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = ADDR_A;
        @(negedge clk);
        cmd_valid = 1'b0;
        tbl_wr_en = 1'b1; tbl_wr_top = 1'b0; tbl_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        model_cmd(2'd0, ADDR_A);
        chk("R11 busy write ignored", {table_hi, table_lo}, m_tab);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule